// File: doc/BRIEF.md
# Event and Cycle Performance Counter Unit

This block counts activity for a larger subsystem. It has one free-running cycle counter and a parameterised bank of event counters, four by default. Each event counter watches one of sixteen external event lines. The event type stored for that counter chooses the line. Software reaches every register through a single-cycle write strobe and a combinational read port. The event counters and their type codes sit behind an index register, so two data addresses serve the whole bank.

Counting is gated in two stages. A global enable in the control register sits above a per-counter enable mask, and that mask is changed only through separate set and clear addresses. When a counter wraps from all ones to zero it sets a sticky overflow flag, and software clears the flag by writing a one to it. An interrupt-enable mask selects which flags drive the single interrupt line. The cycle counter can optionally advance once every 64 clocks.

Top module: `perf_mon`

## Requirements
- R1: After reset all counters, the enable mask, the interrupt mask, the overflow flags, the event types and the index read as zero, and `irq` is low.
- R2: The control register (address 0) holds the global enable in bit 0 and the divide-by-64 select in bit 3. Writing bit 1 zeroes all event counters. Writing bit 2 zeroes the cycle counter. Bits 1 and 2 always read as zero. Bits 31:24 read the implementor code, bits 23:16 read the unit ID, and bits 15:11 read the number of event counters.
- R3: Mask bit i (0..3) stands for event counter i and bit 31 for the cycle counter. Writing ones to the set address (1) enables those counters. Writing ones to the clear address (2) disables them. Zero bits and unimplemented bits are left unchanged, and both addresses read back the mask.
- R4: While the global enable is 0, no counter advances, whatever the mask holds.
- R5: An enabled event counter adds one on every clock in which the event line named by its 4-bit type code is high. Other lines have no effect on it.
- R6: An enabled cycle counter (address 8) adds one every clock when bit 3 is 0. When bit 3 is 1 it adds one on the 64th clock after its prescaler restarts, and on every 64th clock after that.
- R7: A counter that wraps from all ones to zero sets its overflow flag, which uses the mask bit positions (address 3). Writing a one to a flag clears it. If a wrap and a clear of the same flag fall in one cycle, the flag ends set.
- R8: `irq` is high exactly when some overflow flag is set whose bit is also set in the interrupt-enable mask. Software adds bits to that mask by writing ones to address 4.
- R9: Writes to the counter data (address 6) and to the cycle counter load the written value, and that value takes priority over counting in that cycle.
- R10: The index (address 5) selects the event counter behind data address 6 and the type code behind address 7. An index of 4 or more makes both read zero and makes writes to them change nothing.
- R11: The prescaler restarts from zero whenever the cycle counter is reset or the divide select changes value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| ev_in | input | 16 | Event lines |
| irq | output | 1 | Overflow interrupt |

## Verification
A counter can wrap in the same clock that software writes a one to clear the flag that wrap sets. The bench loads an event counter with all ones. It then raises that counter's event line in the very cycle that carries the write to the overflow address, and it expects the flag and the interrupt still to be set afterwards. The same reasoning covers a direct counter load and an event pulse in one cycle, where the loaded value must win and no flag may appear.

// File: rtl/perf_mon.sv
module perf_mon #(
  parameter int          NUM_EV    = 4,
  parameter int          CNT_W     = 32,
  parameter int          EV_LINES  = 16,
  parameter int          ADDR_W    = 4,
  parameter logic [7:0]  IMPL_CODE = 8'hA5,
  parameter logic [7:0]  UNIT_ID   = 8'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [EV_LINES-1:0] ev_in,
  output logic              irq
);
  localparam int TYPE_W = $clog2(EV_LINES);
  localparam int SEL_W  = 5;
  localparam int PRE_W  = 6;
  localparam int CYC_B  = 31;
  localparam logic [31:0] VMASK = 32'h8000_0000 | ((32'h1 << NUM_EV) - 32'h1);

  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_ENSET  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_ENCLR  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_OVF    = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_INTSET = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_SEL    = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_EVCNT  = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_EVTYPE = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_CYC    = ADDR_W'(8);

  logic              ctrl_en, ctrl_div;
  logic [31:0]       cen, ovf, inten;
  logic [SEL_W-1:0]  sel;
  logic [CNT_W-1:0]  ev_cnt  [NUM_EV];
  logic [TYPE_W-1:0] ev_type [NUM_EV];
  logic [CNT_W-1:0]  cyc_cnt;
  logic [PRE_W-1:0]  pre;

  logic wr_ctrl, wr_evcnt, wr_evtype, wr_cyc;
  assign wr_ctrl   = reg_we && reg_addr == A_CTRL;
  assign wr_evcnt  = reg_we && reg_addr == A_EVCNT;
  assign wr_evtype = reg_we && reg_addr == A_EVTYPE;
  assign wr_cyc    = reg_we && reg_addr == A_CYC;

  logic ev_rst, cyc_rst, div_chg, cyc_run, cyc_tick, cyc_wrap;
  assign ev_rst   = wr_ctrl && reg_wdata[1];
  assign cyc_rst  = wr_ctrl && reg_wdata[2];
  assign div_chg  = wr_ctrl && (reg_wdata[3] != ctrl_div);
  assign cyc_run  = ctrl_en && cen[CYC_B];
  assign cyc_tick = cyc_run && (!ctrl_div || (&pre));
  assign cyc_wrap = cyc_tick && !cyc_rst && !wr_cyc && (&cyc_cnt);

  logic [NUM_EV-1:0] ev_hit, ev_wr, ev_wrap;
  always_comb begin
    for (int i = 0; i < NUM_EV; i++) begin
      ev_hit[i]  = ctrl_en && cen[i] && ev_in[ev_type[i]];
      ev_wr[i]   = wr_evcnt && sel == SEL_W'(i);
      ev_wrap[i] = ev_hit[i] && !ev_rst && !ev_wr[i] && (&ev_cnt[i]);
    end
  end

  logic [31:0] wrap_v, clr_v;
  always_comb begin
    wrap_v = '0;
    wrap_v[CYC_B] = cyc_wrap;
    for (int i = 0; i < NUM_EV; i++) wrap_v[i] = ev_wrap[i];
  end
  assign clr_v = (reg_we && reg_addr == A_OVF) ? (reg_wdata & VMASK) : 32'h0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en  <= 1'b0;
      ctrl_div <= 1'b0;
      cen      <= '0;
      ovf      <= '0;
      inten    <= '0;
      sel      <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_en  <= reg_wdata[0];
        ctrl_div <= reg_wdata[3];
      end
      if (reg_we && reg_addr == A_ENSET) cen <= cen | (reg_wdata & VMASK);
      if (reg_we && reg_addr == A_ENCLR) cen <= cen & ~reg_wdata;
      if (reg_we && reg_addr == A_INTSET) inten <= inten | (reg_wdata & VMASK);
      if (reg_we && reg_addr == A_SEL) sel <= reg_wdata[SEL_W-1:0];
      ovf <= (ovf & ~clr_v) | wrap_v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_EV; i++) begin
        ev_cnt[i]  <= '0;
        ev_type[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_EV; i++) begin
        if (ev_rst)         ev_cnt[i] <= '0;
        else if (ev_wr[i])  ev_cnt[i] <= reg_wdata[CNT_W-1:0];
        else if (ev_hit[i]) ev_cnt[i] <= ev_cnt[i] + 1'b1;
        if (wr_evtype && sel == SEL_W'(i)) ev_type[i] <= reg_wdata[TYPE_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_cnt <= '0;
      pre     <= '0;
    end else begin
      if (cyc_rst)       cyc_cnt <= '0;
      else if (wr_cyc)   cyc_cnt <= reg_wdata[CNT_W-1:0];
      else if (cyc_tick) cyc_cnt <= cyc_cnt + 1'b1;
      if (cyc_rst || div_chg)       pre <= '0;
      else if (cyc_run && ctrl_div) pre <= pre + 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:   reg_rdata = {IMPL_CODE, UNIT_ID, 5'(NUM_EV), 7'b0, ctrl_div, 2'b00, ctrl_en};
      A_ENSET,
      A_ENCLR:  reg_rdata = cen;
      A_OVF:    reg_rdata = ovf;
      A_INTSET: reg_rdata = inten;
      A_SEL:    reg_rdata = 32'(sel);
      A_EVCNT:  for (int i = 0; i < NUM_EV; i++)
                  if (sel == SEL_W'(i)) reg_rdata = 32'(ev_cnt[i]);
      A_EVTYPE: for (int i = 0; i < NUM_EV; i++)
                  if (sel == SEL_W'(i)) reg_rdata = 32'(ev_type[i]);
      A_CYC:    reg_rdata = 32'(cyc_cnt);
      default:  reg_rdata = '0;
    endcase
  end

  assign irq = |(ovf & inten);
endmodule

// File: rtl/perf_mon_chk.sv
module perf_mon_chk #(
  parameter int NUM_EV = 4,
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic              irq,
  input logic              ctrl_en,
  input logic              ctrl_div,
  input logic              cyc_en,
  input logic [31:0]       ovf,
  input logic [31:0]       inten,
  input logic [4:0]        sel,
  input logic [CNT_W-1:0]  cyc_cnt,
  input logic [5:0]        pre
);
  p_ctrl_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(0)) |-> (reg_rdata[2:1] == 2'b00));

  p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_en && !reg_we) |=> $stable(cyc_cnt));

  p_prescale_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_div && !reg_we && !(&pre)) |=> $stable(cyc_cnt));

  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_en && cyc_en && !ctrl_div && (&cyc_cnt) && !reg_we) |=> (ovf[31] && cyc_cnt == '0));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf[31] && !reg_we) |=> ovf[31]);

  p_irq_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (inten == 32'h0) |-> !irq);

  p_oor_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(6) && sel >= 5'(NUM_EV)) |-> (reg_rdata == 32'h0));
endmodule

bind perf_mon perf_mon_chk #(.NUM_EV(NUM_EV), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .irq(irq), .ctrl_en(ctrl_en), .ctrl_div(ctrl_div),
  .cyc_en(cen[31]), .ovf(ovf), .inten(inten), .sel(sel),
  .cyc_cnt(cyc_cnt), .pre(pre)
);

// File: tb/sim_perf_mon.sv
module sim_perf_mon;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] A_CTRL = 4'd0, A_ENSET = 4'd1, A_ENCLR = 4'd2, A_OVF = 4'd3,
                         A_INTSET = 4'd4, A_SEL = 4'd5, A_EVCNT = 4'd6, A_EVTYPE = 4'd7,
                         A_CYC = 4'd8;
  localparam logic [31:0] ID_BITS = 32'hA53C_2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] ev_in = '0;
  logic        irq;
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  perf_mon u0 (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
               .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_in(ev_in), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input int line, input int cycles);
    @(negedge clk);
    ev_in[line] = 1'b1;
    repeat (cycles) @(negedge clk);
    ev_in[line] = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_CTRL, v);  chk("R1/R2 ctrl after reset", v, ID_BITS);
    rd(A_ENSET, v); chk("R1 enable mask", v, 0);
    rd(A_OVF, v);   chk("R1 overflow flags", v, 0);
    rd(A_CYC, v);   chk("R1 cycle count", v, 0);
    rd(A_EVCNT, v); chk("R1 event count 0", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_enables;
    logic [31:0] v;
    wr(A_ENSET, 32'h8000_0005); rd(A_ENSET, v); chk("R3 set", v, 32'h8000_0005);
    wr(A_ENSET, 32'h0000_0002); rd(A_ENSET, v); chk("R3 set keeps others", v, 32'h8000_0007);
    wr(A_ENCLR, 32'h0000_0004); rd(A_ENCLR, v); chk("R3 clear one bit", v, 32'h8000_0003);
    wr(A_ENSET, 32'hFFFF_FFFF); rd(A_ENSET, v); chk("R3 unimplemented bits", v, 32'h8000_000F);
    wr(A_ENCLR, 32'hFFFF_FFFF); rd(A_ENSET, v); chk("R3 clear all", v, 0);
  endtask

  task automatic t_events;
    logic [31:0] v;
    wr(A_CTRL, 32'h1);
    wr(A_SEL, 2); wr(A_EVTYPE, 5);
    rd(A_EVTYPE, v); chk("R10 type readback", v, 5);
    wr(A_ENSET, 32'h4);
    pulse(5, 3);
    rd(A_EVCNT, v); chk("R5 count on selected line", v, 3);
    pulse(4, 2);
    rd(A_EVCNT, v); chk("R5 other line ignored", v, 3);
    pulse(0, 2);
    wr(A_SEL, 0);
    rd(A_EVCNT, v); chk("R5 disabled counter", v, 0);
  endtask

  task automatic t_global_off;
    logic [31:0] a, v;
    wr(A_ENSET, 32'h8000_0000);
    wr(A_CTRL, 32'h0);
    rd(A_CYC, a);
    pulse(5, 3);
    repeat (5) @(negedge clk);
    rd(A_CYC, v); chk("R4 cycle frozen", v, a);
    wr(A_SEL, 2);
    rd(A_EVCNT, v); chk("R4 event frozen", v, 3);
  endtask

  task automatic t_cycle;
    logic [31:0] v, c;
    wr(A_CTRL, 32'h5);
    rd(A_CYC, v); chk("R2 cycle reset bit", v, 0);
    repeat (10) @(negedge clk);
    rd(A_CYC, v); chk("R6 full rate", v, 10);
    wr(A_CTRL, 32'hD);
    repeat (63) @(negedge clk);
    rd(A_CYC, v); chk("R6 divided, before 64th", v, 0);
    @(negedge clk);
    rd(A_CYC, v); chk("R6 divided, at 64th", v, 1);
    repeat (30) @(negedge clk);
    wr(A_CTRL, 32'h1);
    wr(A_CTRL, 32'h9);
    rd(A_CYC, c);
    repeat (40) @(negedge clk);
    rd(A_CYC, v); chk("R11 prescaler restarted on change", v, c);
    repeat (24) @(negedge clk);
    rd(A_CYC, v); chk("R11 tick after 64 more", v, c + 1);
  endtask

  task automatic t_overflow;
    logic [31:0] v;
    wr(A_CTRL, 32'h1);
    wr(A_ENSET, 32'h2);
    wr(A_SEL, 1); wr(A_EVTYPE, 0);
    wr(A_EVCNT, 32'hFFFF_FFFF);
    rd(A_EVCNT, v); chk("R9 counter load", v, 32'hFFFF_FFFF);
    wr(A_INTSET, 32'h2);
    chk("R8 irq before wrap", {31'b0, irq}, 0);
    pulse(0, 1);
    rd(A_EVCNT, v); chk("R7 wrapped to zero", v, 0);
    rd(A_OVF, v);   chk("R7 flag set", v & 32'h2, 32'h2);
    chk("R8 irq after wrap", {31'b0, irq}, 1);
    wr(A_OVF, 32'h2);
    rd(A_OVF, v);   chk("R7 write one clears", v & 32'h2, 0);
    chk("R8 irq after clear", {31'b0, irq}, 0);
    wr(A_EVCNT, 32'hFFFF_FFFF);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = A_OVF; reg_wdata = 32'h2; ev_in[0] = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; ev_in[0] = 1'b0;
    rd(A_OVF, v);   chk("R7 wrap beats clear", v & 32'h2, 32'h2);
    chk("R8 irq after collision", {31'b0, irq}, 1);
    wr(A_OVF, 32'h2);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = A_EVCNT; reg_wdata = 32'h77; ev_in[0] = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; ev_in[0] = 1'b0;
    rd(A_EVCNT, v); chk("R9 load beats count", v, 32'h77);
    rd(A_OVF, v);   chk("R9 no flag from load", v & 32'h2, 0);
    wr(A_CYC, 32'hFFFF_FFFE);
    repeat (2) @(negedge clk);
    rd(A_CYC, v);   chk("R7 cycle wrapped", v, 0);
    rd(A_OVF, v);   chk("R7 cycle flag", v, 32'h8000_0000);
    chk("R8 irq masked", {31'b0, irq}, 0);
    wr(A_INTSET, 32'h8000_0000);
    chk("R8 irq unmasked", {31'b0, irq}, 1);
  endtask

  task automatic t_event_reset;
    logic [31:0] v;
    wr(A_SEL, 2); wr(A_EVCNT, 32'h10);
    wr(A_CTRL, 32'h3);
    rd(A_EVCNT, v); chk("R2 event reset bit", v, 0);
    wr(A_SEL, 1);
    rd(A_EVCNT, v); chk("R2 event reset all", v, 0);
    rd(A_CTRL, v);  chk("R2 ctrl reads pulse bits zero", v, ID_BITS | 32'h1);
  endtask

  task automatic t_select;
    logic [31:0] v;
    wr(A_SEL, 1); wr(A_EVCNT, 32'h55);
    wr(A_SEL, 4);
    rd(A_EVCNT, v);  chk("R10 oor count read", v, 0);
    rd(A_EVTYPE, v); chk("R10 oor type read", v, 0);
    wr(A_EVCNT, 32'h1234); wr(A_EVTYPE, 3);
    wr(A_SEL, 1);
    rd(A_EVCNT, v);  chk("R10 oor write no effect count", v, 32'h55);
    rd(A_EVTYPE, v); chk("R10 oor write no effect type", v, 0);
    wr(A_SEL, 3);
    rd(A_EVCNT, v);  chk("R10 counter 3 untouched", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_enables;
    t_events;
    t_global_off;
    t_cycle;
    t_overflow;
    t_event_reset;
    t_select;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule